// File: doc/BRIEF.md
# DAC Holding and Trigger Front End

This block is the digital side of one 12-bit digital-to-analog converter channel. A host bus loads a pending (holding) code through one of three write views: right-justified 12-bit, left-justified 12-bit, or an 8-bit coarse view. A small control register sets three things: whether transfers wait for a trigger, which of eight trigger sources is used, and whether the analog output buffer is switched off.

The holding code moves to the output code register in one of two ways. When triggering is off, it moves on its own one clock after every holding update. When triggering is on, it moves only when the selected source fires. Seven sources are hardware pulse inputs, which act on their rising edge. The eighth source is a self-clearing software trigger bit. The output code drives the converter, and the buffer-enable output drives the analog output stage.

Top module: `dac_hold_xfer`

## Requirements
- R1: After a synchronous reset: `dout` = 0, `buf_en` = 1, `sw_trig_bit` = 0, triggering is disabled, and the trigger select is 000.
- R2: A pulse on `wr_r12` loads holding bits [11:0] from `wr_data[11:0]` at that clock edge.
- R3: A pulse on `wr_l12` loads holding bits [11:0] from `wr_data[15:4]` at that clock edge.
- R4: A pulse on `wr_r8` loads holding bits [11:4] from `wr_data[7:0]` and forces holding bits [3:0] to zero.
- R5: If several write strobes are high in the same cycle, `wr_r12` wins over `wr_l12`, and `wr_l12` wins over `wr_r8`.
- R6: With triggering disabled, `dout` takes the holding value one clock after the holding register is written, so it shows the new code after the second rising edge that follows the write strobe.
- R7: With triggering enabled, `dout` holds its value in every cycle without a selected trigger event, whatever the holding writes.
- R8: With triggering enabled and select code k in 0..6, a rising edge on `hw_trig[k]` copies the holding value to `dout` at the edge where the input is first seen high. An input held high causes only one transfer, and edges on unselected inputs cause none.
- R9: A pulse on `sw_trig_set` makes `sw_trig_bit` read 1 for exactly one cycle, and it clears on the next edge. With triggering enabled and select 111, that next edge also copies the holding value to `dout`. In any other mode the bit clears without a transfer.
- R10: `buf_en` equals the inverse of the buffer-off bit. A control write (`ctl_we`) takes effect at the next edge.
- R11: When a holding write and a trigger event fall on the same edge, `dout` receives the holding value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_r12 | input | 1 | Right-justified 12-bit holding write strobe |
| wr_l12 | input | 1 | Left-justified 12-bit holding write strobe |
| wr_r8 | input | 1 | 8-bit coarse holding write strobe |
| wr_data | input | 16 | Write data bus |
| ctl_we | input | 1 | Control register write strobe |
| ctl_trig_en | input | 1 | Control data: 1 = transfer on trigger, 0 = automatic |
| ctl_trig_sel | input | 3 | Control data: trigger source code (0..6 hardware, 7 software) |
| ctl_buf_off | input | 1 | Control data: 1 switches the output buffer off |
| sw_trig_set | input | 1 | Writes 1 to the software trigger bit |
| hw_trig | input | 7 | Hardware trigger pulse inputs |
| dout | output | 12 | Output code to the converter |
| buf_en | output | 1 | Output buffer enable |
| sw_trig_bit | output | 1 | Readback of the software trigger bit |

## Verification
A corrupted holding register stays hidden in triggered mode until the next transfer. In automatic mode it shows on `dout` one cycle after the write. A stuck edge detector shows up as either a missing transfer or a repeated one while a trigger input stays high, and it is visible on `dout` on the same edge. A software trigger bit that fails to clear shows on `sw_trig_bit` one cycle after it was set. The bench runs a behavioural model in step with the design and compares `dout`, `buf_en` and `sw_trig_bit` on every clock, so any divergence is reported in the cycle it first appears.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    localparam int CODE_W   = 12;
    localparam int BUS_W    = 16;
    localparam int COARSE_W = 8;
    localparam int HW_SRC_N = 7;
    localparam int SEL_W    = 3;

    typedef enum logic [1:0] {
        LOAD_NONE,
        LOAD_RIGHT,
        LOAD_LEFT,
        LOAD_COARSE
    } load_view_e;

    typedef struct packed {
        logic             trig_en;
        logic [SEL_W-1:0] trig_sel;
        logic             buf_off;
    } dac_ctl_t;

    localparam dac_ctl_t CTL_RESET = '{trig_en: 1'b0, trig_sel: '0, buf_off: 1'b0};

    // Fixed priority among simultaneous strobes: right, then left, then coarse.
    function automatic load_view_e pick_view(input logic r12, input logic l12, input logic r8);
        if (r12)
            return LOAD_RIGHT;
        else if (l12)
            return LOAD_LEFT;
        else if (r8)
            return LOAD_COARSE;
        return LOAD_NONE;
    endfunction

endpackage

// File: rtl/dac_hold_reg.sv
module dac_hold_reg
    import dac_fe_pkg::*;
#(
    parameter int DATA_W   = CODE_W,
    parameter int WBUS_W   = BUS_W,
    parameter int NARROW_W = COARSE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_r12,
    input  logic              wr_l12,
    input  logic              wr_r8,
    input  logic [WBUS_W-1:0] wr_data,
    output logic [DATA_W-1:0] hold_o
);
    localparam int PAD_W = DATA_W - NARROW_W;

    load_view_e        view;
    logic [DATA_W-1:0] right_val;
    logic [DATA_W-1:0] left_val;
    logic [DATA_W-1:0] coarse_val;
    logic [DATA_W-1:0] hold_q;

    assign view       = pick_view(wr_r12, wr_l12, wr_r8);
    assign right_val  = wr_data[DATA_W-1:0];
    assign left_val   = wr_data[WBUS_W-1:WBUS_W-DATA_W];
    assign coarse_val = {wr_data[NARROW_W-1:0], {PAD_W{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_q <= '0;
        end else begin
            unique case (view)
                LOAD_RIGHT:  hold_q <= right_val;
                LOAD_LEFT:   hold_q <= left_val;
                LOAD_COARSE: hold_q <= coarse_val;
                default:     hold_q <= hold_q;
            endcase
        end
    end

    assign hold_o = hold_q;
endmodule

// File: rtl/dac_trig_unit.sv
module dac_trig_unit
    import dac_fe_pkg::*;
#(
    parameter int N_HW  = HW_SRC_N,
    parameter int SEL_B = SEL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig_en,
    input  logic [SEL_B-1:0] trig_sel,
    input  logic [N_HW-1:0]  hw_trig,
    input  logic             sw_set,
    output logic             sw_bit_o,
    output logic             xfer_o
);
    localparam int N_SRC   = 1 << SEL_B;
    localparam int SW_CODE = N_SRC - 1;

    logic [N_HW-1:0]  hw_prev;
    logic [N_HW-1:0]  hw_rise;
    logic [N_SRC-1:0] src_vec;
    logic             sw_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_prev <= '0;
            sw_q    <= 1'b0;
        end else begin
            hw_prev <= hw_trig;
            // A set request wins; otherwise the bit lasts exactly one cycle.
            sw_q    <= sw_set;
        end
    end

    assign hw_rise = hw_trig & ~hw_prev;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        if (i == SW_CODE) begin : g_sw
            assign src_vec[i] = sw_q;
        end else if (i < N_HW) begin : g_hw
            assign src_vec[i] = hw_rise[i];
        end else begin : g_none
            assign src_vec[i] = 1'b0;
        end
    end

    assign xfer_o   = trig_en & src_vec[trig_sel];
    assign sw_bit_o = sw_q;
endmodule

// File: rtl/dac_hold_xfer.sv
module dac_hold_xfer
    import dac_fe_pkg::*;
#(
    parameter int DATA_W   = CODE_W,
    parameter int WBUS_W   = BUS_W,
    parameter int NARROW_W = COARSE_W,
    parameter int N_HW     = HW_SRC_N
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_r12,
    input  logic              wr_l12,
    input  logic              wr_r8,
    input  logic [WBUS_W-1:0] wr_data,
    input  logic              ctl_we,
    input  logic              ctl_trig_en,
    input  logic [SEL_W-1:0]  ctl_trig_sel,
    input  logic              ctl_buf_off,
    input  logic              sw_trig_set,
    input  logic [N_HW-1:0]   hw_trig,
    output logic [DATA_W-1:0] dout,
    output logic              buf_en,
    output logic              sw_trig_bit
);
    dac_ctl_t          ctl_q;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] dout_q;
    logic              xfer;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= CTL_RESET;
        end else if (ctl_we) begin
            ctl_q <= '{trig_en: ctl_trig_en, trig_sel: ctl_trig_sel, buf_off: ctl_buf_off};
        end
    end

    dac_hold_reg #(
        .DATA_W  (DATA_W),
        .WBUS_W  (WBUS_W),
        .NARROW_W(NARROW_W)
    ) u_hold (
        .clk    (clk),
        .rst    (rst),
        .wr_r12 (wr_r12),
        .wr_l12 (wr_l12),
        .wr_r8  (wr_r8),
        .wr_data(wr_data),
        .hold_o (hold_q)
    );

    dac_trig_unit #(
        .N_HW (N_HW),
        .SEL_B(SEL_W)
    ) u_trig (
        .clk     (clk),
        .rst     (rst),
        .trig_en (ctl_q.trig_en),
        .trig_sel(ctl_q.trig_sel),
        .hw_trig (hw_trig),
        .sw_set  (sw_trig_set),
        .sw_bit_o(sw_trig_bit),
        .xfer_o  (xfer)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dout_q <= '0;
        end else if (!ctl_q.trig_en || xfer) begin
            dout_q <= hold_q;
        end
    end

    assign dout   = dout_q;
    assign buf_en = ~ctl_q.buf_off;
endmodule

// File: rtl/dac_hold_xfer_chk.sv
module dac_hold_xfer_chk #(
    parameter int DATA_W   = 12,
    parameter int WBUS_W   = 16,
    parameter int NARROW_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_r12,
    input logic              wr_l12,
    input logic              wr_r8,
    input logic [WBUS_W-1:0] wr_data,
    input logic              ctl_we,
    input logic              ctl_buf_off,
    input logic              sw_trig_set,
    input logic              trig_en,
    input logic              xfer,
    input logic [DATA_W-1:0] hold_q,
    input logic [DATA_W-1:0] dout,
    input logic              buf_en,
    input logic              sw_trig_bit
);
    localparam int PAD_W = DATA_W - NARROW_W;

    // R2
    p_right_load_r2: assert property (@(posedge clk) disable iff (rst)
        wr_r12 |=> hold_q == $past(wr_data[DATA_W-1:0]));

    // R3 with R5 priority
    p_left_load_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_l12 && !wr_r12) |=> hold_q == $past(wr_data[WBUS_W-1:WBUS_W-DATA_W]));

    // R4
    p_coarse_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_r8 && !wr_r12 && !wr_l12) |=> hold_q == {$past(wr_data[NARROW_W-1:0]), {PAD_W{1'b0}}});

    // R6
    p_auto_follow_r6: assert property (@(posedge clk) disable iff (rst)
        !trig_en |=> dout == $past(hold_q));

    // R7
    p_trig_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (trig_en && !xfer) |=> $stable(dout));

    // R9
    p_sw_set_r9: assert property (@(posedge clk) disable iff (rst)
        sw_trig_set |=> sw_trig_bit);

    // R9
    p_sw_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (sw_trig_bit && !sw_trig_set) |=> !sw_trig_bit);

    // R10
    p_buf_ctl_r10: assert property (@(posedge clk) disable iff (rst)
        ctl_we |=> buf_en == !$past(ctl_buf_off));
endmodule

bind dac_hold_xfer dac_hold_xfer_chk #(
    .DATA_W  (DATA_W),
    .WBUS_W  (WBUS_W),
    .NARROW_W(NARROW_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_r12     (wr_r12),
    .wr_l12     (wr_l12),
    .wr_r8      (wr_r8),
    .wr_data    (wr_data),
    .ctl_we     (ctl_we),
    .ctl_buf_off(ctl_buf_off),
    .sw_trig_set(sw_trig_set),
    .trig_en    (ctl_q.trig_en),
    .xfer       (xfer),
    .hold_q     (hold_q),
    .dout       (dout),
    .buf_en     (buf_en),
    .sw_trig_bit(sw_trig_bit)
);

// File: tb/tb_dac_hold_xfer.sv
`timescale 1ns/1ps
module tb_dac_hold_xfer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_r12 = 0, wr_l12 = 0, wr_r8 = 0;
    logic [15:0] wr_data = '0;
    logic        ctl_we = 0, ctl_trig_en = 0, ctl_buf_off = 0;
    logic [2:0]  ctl_trig_sel = '0;
    logic        sw_trig_set = 0;
    logic [6:0]  hw_trig = '0;
    logic [11:0] dout;
    logic        buf_en;
    logic        sw_trig_bit;

    int total = 0;
    int bad   = 0;
    bit model_on = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dac_hold_xfer dut (
        .clk(clk), .rst(rst), .wr_r12(wr_r12), .wr_l12(wr_l12), .wr_r8(wr_r8),
        .wr_data(wr_data), .ctl_we(ctl_we), .ctl_trig_en(ctl_trig_en),
        .ctl_trig_sel(ctl_trig_sel), .ctl_buf_off(ctl_buf_off),
        .sw_trig_set(sw_trig_set), .hw_trig(hw_trig),
        .dout(dout), .buf_en(buf_en), .sw_trig_bit(sw_trig_bit)
    );

    // Behavioural reference model
    int m_hold, m_dout, m_sel;
    bit m_en, m_off, m_sw;
    bit [6:0] m_prev;

    always @(posedge clk) begin
        bit ev;
        if (rst) begin
            m_hold = 0; m_dout = 0; m_en = 0; m_sel = 0; m_off = 0; m_sw = 0; m_prev = '0;
        end else begin
            if (m_sel == 7) ev = m_sw;
            else            ev = hw_trig[m_sel] && !m_prev[m_sel];
            if (!m_en || ev) m_dout = m_hold;
            if (wr_r12)      m_hold = wr_data & 16'h0FFF;
            else if (wr_l12) m_hold = wr_data >> 4;
            else if (wr_r8)  m_hold = (wr_data & 16'h00FF) << 4;
            m_sw = sw_trig_set;
            if (ctl_we) begin
                m_en = ctl_trig_en; m_sel = ctl_trig_sel; m_off = ctl_buf_off;
            end
            m_prev = hw_trig;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (model_on && !rst) begin
            chk(m_en ? "R7/R8 model dout" : "R6 model dout", dout, m_dout);
            chk("R10 model buf_en", buf_en, !m_off);
            chk("R9 model sw bit", sw_trig_bit, m_sw);
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int kind, input logic [15:0] d);
        wr_data = d;
        wr_r12 = (kind == 0); wr_l12 = (kind == 1); wr_r8 = (kind == 2);
        tick();
        wr_r12 = 0; wr_l12 = 0; wr_r8 = 0;
    endtask

    task automatic ctl(input bit en, input logic [2:0] sel, input bit off);
        ctl_we = 1; ctl_trig_en = en; ctl_trig_sel = sel; ctl_buf_off = off;
        tick();
        ctl_we = 0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        model_on = 1;
        chk("R1 dout", dout, 0);
        chk("R1 buf_en", buf_en, 1);
        chk("R1 sw bit", sw_trig_bit, 0);

        // Automatic mode, alignment views
        wr(0, 16'hFABC);
        chk("R6 one edge later", dout, 12'h000);
        tick();
        chk("R2 right view", dout, 12'hABC);
        wr(1, 16'h1234); tick();
        chk("R3 left view", dout, 12'h123);
        wr(2, 16'hF0A5); tick();
        chk("R4 coarse view", dout, 12'hA50);
        wr_data = 16'h5678; wr_r12 = 1; wr_l12 = 1; wr_r8 = 1; tick();
        wr_r12 = 0; wr_l12 = 0; wr_r8 = 0; tick();
        chk("R5 right wins", dout, 12'h678);
        wr_data = 16'h9ABC; wr_l12 = 1; wr_r8 = 1; tick();
        wr_l12 = 0; wr_r8 = 0; tick();
        chk("R5 left wins", dout, 12'h9AB);

        // Buffer control
        ctl(0, 3'd0, 1);
        chk("R10 buffer off", buf_en, 0);
        ctl(0, 3'd0, 0);
        chk("R10 buffer on", buf_en, 1);

        // Triggered mode, hardware source 2
        ctl(1, 3'd2, 0);
        wr(0, 16'h0111); tick(); tick();
        chk("R7 no trigger", dout, 12'h9AB);
        hw_trig = 7'b0100000; tick(); hw_trig = '0; tick();
        chk("R8 unselected ignored", dout, 12'h9AB);
        hw_trig = 7'b0000100; tick();
        chk("R8 rising edge", dout, 12'h111);
        wr(0, 16'h0222); tick();
        chk("R8 held high single transfer", dout, 12'h111);
        hw_trig = '0; tick();
        hw_trig = 7'b0000100; wr(0, 16'h0333);
        chk("R11 old value", dout, 12'h222);
        hw_trig = '0; tick();
        chk("R7 write not forwarded", dout, 12'h222);

        // Software trigger
        ctl(1, 3'd7, 0);
        sw_trig_set = 1; tick(); sw_trig_set = 0;
        chk("R9 bit set", sw_trig_bit, 1);
        chk("R9 no early transfer", dout, 12'h222);
        tick();
        chk("R9 bit cleared", sw_trig_bit, 0);
        chk("R9 transfer", dout, 12'h333);
        ctl(1, 3'd2, 0);
        wr(0, 16'h0444);
        sw_trig_set = 1; tick(); sw_trig_set = 0; tick();
        chk("R9 wrong mode clears", sw_trig_bit, 0);
        chk("R9 wrong mode no transfer", dout, 12'h333);

        // Each hardware source
        for (int k = 0; k < 7; k++) begin
            ctl(1, 3'(k), 0);
            wr(0, 16'(12'h500 + k));
            hw_trig = 7'(1 << k); tick(); hw_trig = '0; tick();
            chk("R8 source sweep", dout, 12'h500 + k);
        end

        // Random traffic checked by the model
        for (int n = 0; n < 2000; n++) begin
            wr_data = 16'($urandom);
            wr_r12 = ($urandom % 8) == 0;
            wr_l12 = ($urandom % 8) == 0;
            wr_r8 = ($urandom % 8) == 0;
            hw_trig = 7'($urandom);
            sw_trig_set = ($urandom % 6) == 0;
            ctl_we = ($urandom % 20) == 0;
            ctl_trig_en = 1'($urandom);
            ctl_trig_sel = 3'($urandom);
            ctl_buf_off = ($urandom % 4) == 0;
            tick();
        end
        wr_r12 = 0; wr_l12 = 0; wr_r8 = 0; ctl_we = 0; sw_trig_set = 0; hw_trig = '0;
        tick();

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule